// File: doc/BRIEF.md
# Fractional Reference Clock Enable Generator

This block turns a fast input clock into a clock-enable strobe whose average rate is the input rate times 18 divided by a programmable divisor. Because the divisor is limited to the range 18 to 35, the strobe rate falls between roughly half the input rate and the full input rate. For example, a 480 MHz input with a divisor of 30 gives a 288 MHz-equivalent strobe. The strobe stays in the input clock domain, and downstream logic uses it to qualify its own register updates.

Software programs the block through a single write strobe. Each write carries a 6-bit divisor and a gate bit. A set gate bit holds the strobe low; a clear gate bit lets the strobe run. A divisor outside the usable range is discarded and raises a sticky error flag. A legal divisor written while the strobe is running is held back until the next strobe pulse, so no shortened period is produced. The divisor currently in use is always visible on an output.

A three-state controller drives the sequencing. **GATED** holds the phase accumulator at zero and keeps the strobe low. **RUN** advances the accumulator every cycle. **PEND** also advances the accumulator, but it holds a new divisor waiting for the next wrap. The transitions are:
- GATED→RUN on a write with the gate clear.
- RUN→PEND on a legal write with the gate clear whose divisor differs from the one in use.
- PEND→RUN on an accumulator wrap.
- RUN→GATED and PEND→GATED on any write with the gate set.

Top module: `frac_ref_gen`

## Requirements
- R1: After reset the strobe `tick` is 0, `eff_frac` reads 18, `cfg_err` is 0 and the block is gated, so no strobe appears until a write clears the gate.
- R2: While running with divisor N, any window of N consecutive cycles contains exactly 18 strobe cycles, and `tick` is a one-cycle-wide level sampled once per input cycle.
- R3: With divisor 18, `tick` is high in every cycle after the cycle that ungates the block.
- R4: With divisor 30, exactly 18 strobes appear in every 30 cycles, which is a 288/480 rate ratio.
- R5: A write with `cfg_gate`=1 forces `tick` to 0 from the clock edge that takes the write. A later write with `cfg_gate`=0 restarts from phase zero, so the first window of N cycles again holds exactly 18 strobes.
- R6: A write whose `cfg_frac` is below 18 or above 35 leaves `eff_frac` unchanged and sets `cfg_err`. `cfg_err` stays at 1 through later legal writes until reset.
- R7: A legal divisor written while running becomes effective at the clock edge that produces the next strobe. `eff_frac` keeps the old value until that edge.
- R8: A legal divisor written while gated, or in the same write that sets the gate, takes effect at the clock edge of the write.
- R9: `eff_frac` always reports the divisor the accumulator is using, and its value always lies within 18..35.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle write strobe for `cfg_frac` and `cfg_gate` |
| cfg_frac | input | 6 | Requested divisor; legal range 18..35 |
| cfg_gate | input | 1 | 1 = stop the strobe, 0 = run |
| tick | output | 1 | Clock-enable strobe, registered |
| eff_frac | output | 6 | Divisor currently applied |
| cfg_err | output | 1 | Sticky flag for an illegal divisor write |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor, a numerator of 18, and a legal range of 18 to 35. These values make both range edges reachable, along with the just-outside values 17 and 36. The full-rate case (divisor 18) and the slowest case (divisor 35) are both exercised. Strobe counts are compared over windows whose length equals the divisor, so each comparison has an exact expected value. Single-cycle sampling around a mid-run divisor change shows the deferral to the next wrap.

// File: rtl/frac_ref_pkg.sv
package frac_ref_pkg;

    // Controller states of the strobe generator
    typedef enum logic [1:0] {
        ST_GATED = 2'd0,
        ST_RUN   = 2'd1,
        ST_PEND  = 2'd2
    } fr_state_t;

endpackage

// File: rtl/frac_range_chk.sv
module frac_range_chk #(
    parameter int FRAC_W   = 6,
    parameter int FRAC_MIN = 18,
    parameter int FRAC_MAX = 35
) (
    input  logic [FRAC_W-1:0] value,
    output logic              legal
);
    localparam logic [FRAC_W-1:0] LO = FRAC_W'(FRAC_MIN);
    localparam logic [FRAC_W-1:0] HI = FRAC_W'(FRAC_MAX);

    always_comb begin
        legal = (value >= LO) && (value <= HI);
    end
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
    parameter int FRAC_W = 6,
    parameter int NUMER  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [FRAC_W-1:0] divisor,
    output logic              wrap,
    output logic              tick
);
    localparam int ACC_W = FRAC_W + 1;
    localparam logic [ACC_W-1:0] NUM_V = ACC_W'(NUMER);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;

    always_comb begin
        div_ext = {1'b0, divisor};
        sum     = acc_q + NUM_V;
        wrap    = advance && (sum >= div_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (!advance) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= wrap ? (sum - div_ext) : sum;
            tick  <= wrap;
        end
    end

    // The phase residue stays below the divisor in use (R2)
    p_acc_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div_ext);

    // Stopping the accumulator removes the strobe on the next edge (R5)
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> (!tick && acc_q == '0));
endmodule

// File: rtl/frac_ctrl_fsm.sv
module frac_ctrl_fsm
    import frac_ref_pkg::*;
#(
    parameter int FRAC_W     = 6,
    parameter int FRAC_MIN   = 18,
    parameter int FRAC_MAX   = 35,
    parameter int RESET_FRAC = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              gate_in,
    input  logic              legal,
    input  logic              wrap,
    output logic [FRAC_W-1:0] active_frac,
    output logic              advance,
    output logic              err,
    output logic              is_gated
);
    localparam logic [FRAC_W-1:0] RST_V = FRAC_W'(RESET_FRAC);

    fr_state_t         state_q, state_d;
    logic [FRAC_W-1:0] pend_q;
    logic              wr_gate, wr_run_ok;

    always_comb begin
        wr_gate   = wr && gate_in;
        wr_run_ok = wr && !gate_in && legal;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED: if (wr && !gate_in) state_d = ST_RUN;
            ST_RUN: begin
                if (wr_gate)                                state_d = ST_GATED;
                else if (wr_run_ok && frac_in != active_frac) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (wr_gate)   state_d = ST_GATED;
                else if (wrap) state_d = ST_RUN;
            end
            default: state_d = ST_GATED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GATED;
        else        state_q <= state_d;
    end

    // Registered outputs and held divisor values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_frac <= RST_V;
            pend_q      <= RST_V;
            err         <= 1'b0;
        end else begin
            if (wr && !legal) err <= 1'b1;
            unique case (state_q)
                ST_GATED: begin
                    if (wr && legal) active_frac <= frac_in;
                end
                ST_RUN: begin
                    if (wr_gate && legal) active_frac <= frac_in;
                    if (wr_run_ok)        pend_q      <= frac_in;
                end
                ST_PEND: begin
                    if (wr_gate)        active_frac <= legal ? frac_in : pend_q;
                    else if (wrap)      active_frac <= wr_run_ok ? frac_in : pend_q;
                    if (wr_run_ok)      pend_q      <= frac_in;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        is_gated = (state_q == ST_GATED);
        advance  = !is_gated && !wr_gate;
    end

    // Sticky error (R6)
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // Illegal write while running leaves the divisor alone (R6)
    p_illegal_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !legal && state_q == ST_RUN) |=> $stable(active_frac));

    // A waiting divisor is not applied before a wrap (R7)
    p_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !wrap && !wr) |=> $stable(active_frac));

    // Divisor in use is always legal (R9)
    p_active_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_frac >= FRAC_W'(FRAC_MIN)) && (active_frac <= FRAC_W'(FRAC_MAX)));
endmodule

// File: rtl/frac_ref_gen.sv
module frac_ref_gen #(
    parameter int FRAC_W     = 6,
    parameter int NUMER      = 18,
    parameter int FRAC_MIN   = 18,
    parameter int FRAC_MAX   = 35,
    parameter int RESET_FRAC = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cfg_gate,
    output logic              tick,
    output logic [FRAC_W-1:0] eff_frac,
    output logic              cfg_err
);
    logic legal;
    logic wrap;
    logic advance;
    logic is_gated;

    frac_range_chk #(
        .FRAC_W(FRAC_W), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX)
    ) u_chk (
        .value(cfg_frac),
        .legal(legal)
    );

    frac_ctrl_fsm #(
        .FRAC_W(FRAC_W), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX),
        .RESET_FRAC(RESET_FRAC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .frac_in(cfg_frac), .gate_in(cfg_gate),
        .legal(legal), .wrap(wrap),
        .active_frac(eff_frac), .advance(advance),
        .err(cfg_err), .is_gated(is_gated)
    );

    frac_phase_acc #(
        .FRAC_W(FRAC_W), .NUMER(NUMER)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .advance(advance), .divisor(eff_frac),
        .wrap(wrap), .tick(tick)
    );

    // No strobe while the controller is gated (R5)
    p_gated_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_gated |-> !tick);

    // With divisor 18 the strobe never skips a running cycle (R3)
    p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && eff_frac == FRAC_W'(NUMER)) |=> tick);
endmodule

// File: tb/tb_frac_ref_gen.sv
module tb_frac_ref_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_frac = 6'd0;
    logic       cfg_gate = 1'b0;
    logic       tick;
    logic [5:0] eff_frac;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int obs_q[$];
    string tag_q[$];
    event item_ev;

    always #5 clk = ~clk;

    frac_ref_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_frac(cfg_frac),
        .cfg_gate(cfg_gate), .tick(tick), .eff_frac(eff_frac), .cfg_err(cfg_err)
    );

    // Driver side: push expected and observed item
    task automatic post(input string tag, input int expv, input int obsv);
        exp_q.push_back(expv);
        obs_q.push_back(obsv);
        tag_q.push_back(tag);
        -> item_ev;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) begin
            int e = exp_q.pop_front();
            int o = obs_q.pop_front();
            string t = tag_q.pop_front();
            n_checks++;
            if (e != o) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", t, o, e);
            end
        end
    endtask

    // Monitor: compares items as they arrive
    initial forever begin
        @(item_ev);
        drain();
    end

    task automatic cfg(input logic [5:0] f, input logic g);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_frac = f; cfg_gate = g;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(tick);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        drain();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        post("R1 tick after reset", 0, int'(tick));
        post("R1 eff_frac after reset", 18, int'(eff_frac));
        post("R1 err after reset", 0, int'(cfg_err));
        count_ticks(8, c);
        post("R1 gated after reset", 0, c);

        // R3: full rate
        cfg(6'd18, 1'b0);
        count_ticks(10, c);
        post("R3 divisor 18 ticks in 10", 10, c);

        // R5: gate stops at once
        cfg(6'd18, 1'b1);
        post("R5 tick at gate edge", 0, int'(tick));
        count_ticks(10, c);
        post("R5 ticks while gated", 0, c);

        // R8: applied while gated
        cfg(6'd30, 1'b1);
        post("R8 eff_frac while gated", 30, int'(eff_frac));

        // R4: 30 -> 18 of 30
        cfg(6'd30, 1'b0);
        count_ticks(30, c);
        post("R4 first 30 window", 18, c);
        count_ticks(30, c);
        post("R4 second 30 window", 18, c);

        // R6: illegal values while running
        cfg(6'd17, 1'b0);
        post("R6 err after 17", 1, int'(cfg_err));
        post("R6 eff_frac kept after 17", 30, int'(eff_frac));
        cfg(6'd36, 1'b0);
        post("R6 eff_frac kept after 36", 30, int'(eff_frac));
        count_ticks(30, c);
        post("R6 rate unchanged", 18, c);

        // R2: slowest legal divisor, fresh phase
        cfg(6'd35, 1'b1);
        cfg(6'd35, 1'b0);
        count_ticks(35, c);
        post("R2 divisor 35 window", 18, c);
        cfg(6'd27, 1'b1);
        cfg(6'd27, 1'b0);
        count_ticks(27, c);
        post("R2 divisor 27 window", 18, c);
        post("R6 err still sticky", 1, int'(cfg_err));

        // R7: deferral to the next wrap
        cfg(6'd35, 1'b1);
        cfg(6'd35, 1'b0);
        cfg_wr = 1'b1; cfg_frac = 6'd20; cfg_gate = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        post("R7 eff_frac before wrap", 35, int'(eff_frac));
        post("R7 no tick before wrap", 0, int'(tick));
        @(negedge clk);
        post("R7 tick at wrap", 1, int'(tick));
        post("R9 eff_frac after wrap", 20, int'(eff_frac));
        count_ticks(20, c);
        post("R2 divisor 20 window", 18, c);

        @(negedge clk);
        drain();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule